// File: doc/BRIEF.md
# Multithreaded Execute-Packet Split Issuer

This block is the issue stage of a multithreaded VLIW core. Each hardware thread offers one execute packet (EP) at a time: a set of up to eight operations that were scheduled as mutually independent. Each operation slot carries a unit-kind code and an opaque operation word. The issuer captures the EP and spreads its operations over the functional units that are free. It may send only part of an EP in one cycle and keep the rest pending for later cycles. It never mixes two EPs of the same thread in one cycle.

Threads are served in a fixed priority order, with thread 0 first. Units that thread 0 does not use are offered to threads 1, 2 and 3 in turn. Every functional unit has one issue lane, so a lane is a unit. Lanes are grouped by kind in a fixed order: ALU, shifter, multiplier, load/store. The number of units in each group is a parameter. When the last pending operation of a thread's EP leaves, the issuer pulses that thread's boundary output. Commit logic downstream uses that pulse to count EP boundaries. In the same cycle the thread's ready output lets the next EP in.

Top module: `split_issue_top`

## Requirements
- R1: While reset is asserted and right after it, no lane is valid, no boundary pulse is high, and every thread's epReady is high.
- R2: An EP is captured in a cycle where epValid and epReady are both high for its thread. None of its operations issues in that cycle; they can issue from the next cycle on.
- R3: A lane carries at most one operation per cycle, and only an operation whose 2-bit kind code matches the lane's group. The codes are 0 ALU, 1 shifter, 2 multiplier, 3 load/store. Lanes are numbered from 0: the ALU group first, then shifter, then multiplier, then load/store.
- R4: Thread 0 has the highest priority. Units left free after a thread is served go to the next thread in the order 1, 2, 3.
- R5: Within one thread, operations of the same kind take units in ascending slot order. The n-th one granted uses the n-th lane of its group. An operation that finds no free unit stays pending and is retried the next cycle. For example, with one multiplier, an EP holding two multiplies issues the second one a cycle later.
- R6: All operations issued for a thread in one cycle belong to that thread's current EP. Operations of the following EP never issue in the same cycle as any operation of the previous EP.
- R7: epBoundary of a thread is high exactly in the cycle in which the last pending operation of that thread's EP issues.
- R8: epReady of a thread is high when the thread holds no pending operation, or when its last pending operation issues in that cycle. Otherwise it is low, and a new EP offered on that thread is not taken.
- R9: A thread with no EP issues nothing and raises no boundary. An EP whose slot mask is all zero is accepted and then produces neither an issue nor a boundary.
- R10: Each issued lane reports the thread number, the slot index and the operation word as they were at capture time. Changes on a thread's input fields while its EP is held have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| epValid | input | EP_THREADS | Per thread: an EP is offered |
| epOpMask | input | EP_THREADS x EP_SLOTS | Per thread: which slots of the offered EP hold an operation |
| epOpKind | input | EP_THREADS x EP_SLOTS x 2 | Per slot unit-kind code (0 ALU, 1 shifter, 2 multiplier, 3 load/store) |
| epOpWord | input | EP_THREADS x EP_SLOTS x OP_WORD_W | Per slot operation word |
| epReady | output | EP_THREADS | Per thread: the next EP is taken this cycle if offered |
| issueValid | output | LANES | Per unit: an operation issues on this lane |
| issueThread | output | LANES x THR_W | Thread of the issued operation |
| issueSlot | output | LANES x SLOT_W | Slot index of the issued operation in its EP |
| issueWord | output | LANES x OP_WORD_W | Operation word of the issued operation (zero when the lane is idle) |
| epBoundary | output | EP_THREADS | Per thread: the last operation of the current EP issues this cycle |

## Verification
The bench builds the issuer with two ALUs, two shifters, one multiplier and two load/store units, which gives seven lanes, and with all four threads active. The single multiplier forces two-multiply EPs to split across cycles and slot order to decide which multiply goes first. The two-wide ALU group lets four threads competing for ALUs show strict priority fill and the starving of low-priority threads. A closing random phase adds bubbles, all-zero EPs, and garbage on the inputs of threads that are holding an EP.

// File: rtl/split_issue_pkg.sv
package split_issue_pkg;

  // Thread and packet shape shared by every module of the issuer
  localparam int EP_THREADS = 4;
  localparam int EP_SLOTS   = 8;
  localparam int OP_WORD_W  = 16;
  localparam int NUM_KINDS  = 4;
  localparam int MAX_LANES  = 8;

  localparam int THR_W  = $clog2(EP_THREADS);
  localparam int SLOT_W = $clog2(EP_SLOTS);
  localparam int LIDX_W = $clog2(MAX_LANES);

  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_SHIFT = 2'd1,
    KIND_MUL   = 2'd2,
    KIND_MEM   = 2'd3
  } unit_kind_e;

  // Selection for one issue lane
  typedef struct packed {
    logic              vld;
    logic [THR_W-1:0]  thr;
    logic [SLOT_W-1:0] slot;
  } lane_sel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [EP_THREADS-1:0]           load;
    lane_sel_t [MAX_LANES-1:0]       lane;
  } ctrl_strobe_t;

endpackage

// File: rtl/split_issue_ctrl.sv
module split_issue_ctrl
  import split_issue_pkg::*;
#(
  parameter int ALU_UNITS   = 2,
  parameter int SHIFT_UNITS = 2,
  parameter int MUL_UNITS   = 2,
  parameter int MEM_UNITS   = 2
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [EP_THREADS-1:0]                   epValid,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0]     epOpMask,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0] heldKind,
  output ctrl_strobe_t                            strb,
  output logic [EP_THREADS-1:0]                   epReady,
  output logic [EP_THREADS-1:0]                   epBoundary
);

  localparam int KIND_UNITS [NUM_KINDS] = '{ALU_UNITS, SHIFT_UNITS, MUL_UNITS, MEM_UNITS};
  localparam int KIND_BASE  [NUM_KINDS] = '{0, ALU_UNITS, ALU_UNITS + SHIFT_UNITS,
                                            ALU_UNITS + SHIFT_UNITS + MUL_UNITS};

  logic [EP_THREADS-1:0][EP_SLOTS-1:0] pendQ;
  logic [EP_THREADS-1:0][EP_SLOTS-1:0] grant;
  logic [EP_THREADS-1:0]               loadV;
  lane_sel_t [MAX_LANES-1:0]           laneSel;
  int                                  useCnt [NUM_KINDS];
  int                                  kIdx;

  // Single priority pass: threads in order, slots in order inside a thread
  always_comb begin
    for (int k = 0; k < NUM_KINDS; k++) useCnt[k] = 0;
    kIdx    = 0;
    grant   = '0;
    laneSel = '0;
    for (int t = 0; t < EP_THREADS; t++) begin
      for (int s = 0; s < EP_SLOTS; s++) begin
        if (pendQ[t][s]) begin
          kIdx = int'(heldKind[t][s]);
          if (useCnt[kIdx] < KIND_UNITS[kIdx]) begin
            grant[t][s] = 1'b1;
            laneSel[LIDX_W'(KIND_BASE[kIdx] + useCnt[kIdx])].vld  = 1'b1;
            laneSel[LIDX_W'(KIND_BASE[kIdx] + useCnt[kIdx])].thr  = THR_W'(t);
            laneSel[LIDX_W'(KIND_BASE[kIdx] + useCnt[kIdx])].slot = SLOT_W'(s);
            useCnt[kIdx] = useCnt[kIdx] + 1;
          end
        end
      end
    end
  end

  for (genvar t = 0; t < EP_THREADS; t++) begin : g_thr
    assign epBoundary[t] = (|pendQ[t]) && ((pendQ[t] & ~grant[t]) == '0);
    assign epReady[t]    = ~(|pendQ[t]) | epBoundary[t];
    assign loadV[t]      = epValid[t] & epReady[t];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      for (int t = 0; t < EP_THREADS; t++) begin
        if (loadV[t]) pendQ[t] <= epOpMask[t];
        else          pendQ[t] <= pendQ[t] & ~grant[t];
      end
    end
  end

  assign strb = '{load: loadV, lane: laneSel};

endmodule

// File: rtl/split_issue_dp.sv
module split_issue_dp
  import split_issue_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  ctrl_strobe_t                                    strb,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0]        epOpKind,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0][OP_WORD_W-1:0] epOpWord,
  output logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0]        heldKind,
  output logic [LANES-1:0]                                issueValid,
  output logic [LANES-1:0][THR_W-1:0]                     issueThread,
  output logic [LANES-1:0][SLOT_W-1:0]                    issueSlot,
  output logic [LANES-1:0][OP_WORD_W-1:0]                 issueWord
);

  logic [EP_THREADS-1:0][EP_SLOTS-1:0][OP_WORD_W-1:0] heldWord;

  // Packet storage, written only when the control accepts a new EP
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldKind <= '0;
      heldWord <= '0;
    end else begin
      for (int t = 0; t < EP_THREADS; t++) begin
        if (strb.load[t]) begin
          heldKind[t] <= epOpKind[t];
          heldWord[t] <= epOpWord[t];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign issueValid[l]  = strb.lane[l].vld;
    assign issueThread[l] = strb.lane[l].thr;
    assign issueSlot[l]   = strb.lane[l].slot;
    assign issueWord[l]   = strb.lane[l].vld ?
                            heldWord[strb.lane[l].thr][strb.lane[l].slot] : '0;
  end

  if (LANES < MAX_LANES) begin : g_spare
    logic unusedSpareLanes;
    assign unusedSpareLanes = ^strb.lane[MAX_LANES-1:LANES];
  end

endmodule

// File: rtl/split_issue_top.sv
module split_issue_top
  import split_issue_pkg::*;
#(
  parameter int ALU_UNITS   = 2,
  parameter int SHIFT_UNITS = 2,
  parameter int MUL_UNITS   = 2,
  parameter int MEM_UNITS   = 2,
  localparam int LANES      = ALU_UNITS + SHIFT_UNITS + MUL_UNITS + MEM_UNITS
) (
  input  logic                                              clk,
  input  logic                                              rstN,
  input  logic [EP_THREADS-1:0]                             epValid,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0]               epOpMask,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0]          epOpKind,
  input  logic [EP_THREADS-1:0][EP_SLOTS-1:0][OP_WORD_W-1:0] epOpWord,
  output logic [EP_THREADS-1:0]                             epReady,
  output logic [LANES-1:0]                                  issueValid,
  output logic [LANES-1:0][THR_W-1:0]                       issueThread,
  output logic [LANES-1:0][SLOT_W-1:0]                      issueSlot,
  output logic [LANES-1:0][OP_WORD_W-1:0]                   issueWord,
  output logic [EP_THREADS-1:0]                             epBoundary
);

  ctrl_strobe_t                             strb;
  logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0] heldKind;

  split_issue_ctrl #(
    .ALU_UNITS  (ALU_UNITS),
    .SHIFT_UNITS(SHIFT_UNITS),
    .MUL_UNITS  (MUL_UNITS),
    .MEM_UNITS  (MEM_UNITS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .epValid   (epValid),
    .epOpMask  (epOpMask),
    .heldKind  (heldKind),
    .strb      (strb),
    .epReady   (epReady),
    .epBoundary(epBoundary)
  );

  split_issue_dp #(
    .LANES(LANES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .epOpKind   (epOpKind),
    .epOpWord   (epOpWord),
    .heldKind   (heldKind),
    .issueValid (issueValid),
    .issueThread(issueThread),
    .issueSlot  (issueSlot),
    .issueWord  (issueWord)
  );

endmodule

// File: rtl/split_issue_chk.sv
module split_issue_chk
  import split_issue_pkg::*;
#(
  parameter int ALU_UNITS   = 2,
  parameter int SHIFT_UNITS = 2,
  parameter int MUL_UNITS   = 2,
  parameter int MEM_UNITS   = 2,
  localparam int LANES      = ALU_UNITS + SHIFT_UNITS + MUL_UNITS + MEM_UNITS
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [LANES-1:0]              issueValid,
  input logic [LANES-1:0][THR_W-1:0]   issueThread,
  input logic [EP_THREADS-1:0]         epBoundary,
  input logic [EP_THREADS-1:0]         epReady
);

  localparam int KIND_UNITS [NUM_KINDS] = '{ALU_UNITS, SHIFT_UNITS, MUL_UNITS, MEM_UNITS};
  localparam int KIND_BASE  [NUM_KINDS] = '{0, ALU_UNITS, ALU_UNITS + SHIFT_UNITS,
                                            ALU_UNITS + SHIFT_UNITS + MUL_UNITS};

  logic [EP_THREADS-1:0] thrIssued;

  always_comb begin
    thrIssued = '0;
    for (int l = 0; l < LANES; l++)
      if (issueValid[l]) thrIssued[issueThread[l]] = 1'b1;
  end

  for (genvar t = 0; t < EP_THREADS; t++) begin : g_thr
    // R7: a boundary only comes with an issue from that thread
    p_boundary_issues_r7: assert property (@(posedge clk) disable iff (!rstN)
      epBoundary[t] |-> thrIssued[t]);
    // R8: the thread takes its next EP in the boundary cycle
    p_boundary_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
      epBoundary[t] |-> epReady[t]);
    // R9: an idle thread issues nothing
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
      (epReady[t] && !epBoundary[t]) |-> !thrIssued[t]);
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    for (genvar u = 1; u < KIND_UNITS[k]; u++) begin : g_unit
      // R5: units of a group fill from the lowest lane upward
      p_group_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
        issueValid[KIND_BASE[k] + u] |-> issueValid[KIND_BASE[k] + u - 1]);
    end
  end

endmodule

bind split_issue_top split_issue_chk #(
  .ALU_UNITS  (ALU_UNITS),
  .SHIFT_UNITS(SHIFT_UNITS),
  .MUL_UNITS  (MUL_UNITS),
  .MEM_UNITS  (MEM_UNITS)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueThread(issueThread),
  .epBoundary (epBoundary),
  .epReady    (epReady)
);

// File: tb/test_split_issue_top.sv
`timescale 1ns/1ps
module test_split_issue_top;
  import split_issue_pkg::*;

  localparam int ALU_N = 2;
  localparam int SHF_N = 2;
  localparam int MUL_N = 1;
  localparam int MEM_N = 2;
  localparam int LN    = ALU_N + SHF_N + MUL_N + MEM_N;
  localparam int CNT  [4] = '{ALU_N, SHF_N, MUL_N, MEM_N};
  localparam int BASE [4] = '{0, ALU_N, ALU_N + SHF_N, ALU_N + SHF_N + MUL_N};

  typedef struct packed {
    logic [EP_SLOTS-1:0]                mask;
    logic [EP_SLOTS-1:0][1:0]           kind;
    logic [EP_SLOTS-1:0][OP_WORD_W-1:0] word;
  } ep_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [EP_THREADS-1:0]                              epValid = '0;
  logic [EP_THREADS-1:0][EP_SLOTS-1:0]                epOpMask = '0;
  logic [EP_THREADS-1:0][EP_SLOTS-1:0][1:0]           epOpKind = '0;
  logic [EP_THREADS-1:0][EP_SLOTS-1:0][OP_WORD_W-1:0] epOpWord = '0;
  logic [EP_THREADS-1:0]                              epReady;
  logic [LN-1:0]                                      issueValid;
  logic [LN-1:0][THR_W-1:0]                           issueThread;
  logic [LN-1:0][SLOT_W-1:0]                          issueSlot;
  logic [LN-1:0][OP_WORD_W-1:0]                       issueWord;
  logic [EP_THREADS-1:0]                              epBoundary;

  split_issue_top #(
    .ALU_UNITS(ALU_N), .SHIFT_UNITS(SHF_N), .MUL_UNITS(MUL_N), .MEM_UNITS(MEM_N)
  ) i_split_issue_top (
    .clk(clk), .rstN(rstN), .epValid(epValid), .epOpMask(epOpMask),
    .epOpKind(epOpKind), .epOpWord(epOpWord), .epReady(epReady),
    .issueValid(issueValid), .issueThread(issueThread), .issueSlot(issueSlot),
    .issueWord(issueWord), .epBoundary(epBoundary)
  );

  always #10 clk = ~clk;

  int    compared   = 0;
  int    mismatched = 0;
  bit    finished   = 0;
  bit    allowBubble = 0;
  string curReq = "R1";

  ep_t                 srcQ [EP_THREADS][$];
  ep_t                 heldEp [EP_THREADS];
  logic [EP_SLOTS-1:0] pendM [EP_THREADS];
  logic [EP_SLOTS-1:0] xGrant [EP_THREADS];
  logic [LN-1:0]       xVld;
  int                  xThr [LN];
  int                  xSlot [LN];
  int                  xWord [LN];
  logic [EP_THREADS-1:0] xBnd, xRdy;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic ep_t mkEp(input logic [EP_SLOTS-1:0] m, input logic [15:0] k);
    ep_t e;
    e.mask = m;
    e.kind = k;
    for (int s = 0; s < EP_SLOTS; s++) e.word[s] = OP_WORD_W'($urandom);
    return e;
  endfunction

  // Expected outputs of this cycle from the behavioural state
  task automatic modelPredict();
    int used [4];
    for (int k = 0; k < 4; k++) used[k] = 0;
    xVld = '0;
    for (int l = 0; l < LN; l++) begin xThr[l] = 0; xSlot[l] = 0; xWord[l] = 0; end
    for (int t = 0; t < EP_THREADS; t++) begin
      xGrant[t] = '0;
      for (int s = 0; s < EP_SLOTS; s++) begin
        if (pendM[t][s]) begin
          int k = int'(heldEp[t].kind[s]);
          if (used[k] < CNT[k]) begin
            int l = BASE[k] + used[k];
            xVld[l]  = 1'b1;
            xThr[l]  = t;
            xSlot[l] = s;
            xWord[l] = int'(heldEp[t].word[s]);
            used[k]++;
            xGrant[t][s] = 1'b1;
          end
        end
      end
      xBnd[t] = (pendM[t] != 0) && ((pendM[t] & ~xGrant[t]) == 0);
      xRdy[t] = (pendM[t] == 0) || xBnd[t];
    end
  endtask

  task automatic driveInputs();
    for (int t = 0; t < EP_THREADS; t++) begin
      bit bubble = allowBubble && ($urandom % 4 == 0);
      epValid[t] = (srcQ[t].size() > 0) && !bubble;
      if (xRdy[t] && srcQ[t].size() > 0) begin
        epOpMask[t] = srcQ[t][0].mask;
        epOpKind[t] = srcQ[t][0].kind;
        epOpWord[t] = srcQ[t][0].word;
      end else begin
        // R10: garbage on a thread that cannot take a packet
        epOpMask[t] = EP_SLOTS'($urandom);
        epOpKind[t] = (2*EP_SLOTS)'($urandom);
        for (int s = 0; s < EP_SLOTS; s++) epOpWord[t][s] = OP_WORD_W'($urandom);
      end
    end
  endtask

  task automatic compareOut();
    for (int l = 0; l < LN; l++) begin
      check(issueValid[l] == xVld[l], curReq, $sformatf("lane %0d valid", l),
            int'(issueValid[l]), int'(xVld[l]));
      if (xVld[l] && issueValid[l]) begin
        check(int'(issueThread[l]) == xThr[l], curReq, $sformatf("lane %0d thread", l),
              int'(issueThread[l]), xThr[l]);
        check(int'(issueSlot[l]) == xSlot[l], curReq, $sformatf("lane %0d slot", l),
              int'(issueSlot[l]), xSlot[l]);
        check(int'(issueWord[l]) == xWord[l], "R10", $sformatf("lane %0d word", l),
              int'(issueWord[l]), xWord[l]);
      end
    end
    for (int t = 0; t < EP_THREADS; t++) begin
      check(epBoundary[t] == xBnd[t], "R7", $sformatf("boundary thread %0d", t),
            int'(epBoundary[t]), int'(xBnd[t]));
      check(epReady[t] == xRdy[t], "R8", $sformatf("ready thread %0d", t),
            int'(epReady[t]), int'(xRdy[t]));
    end
  endtask

  task automatic modelAdvance();
    for (int t = 0; t < EP_THREADS; t++) begin
      if (epValid[t] && xRdy[t]) begin
        heldEp[t] = srcQ[t].pop_front();
        pendM[t]  = heldEp[t].mask;
      end else begin
        pendM[t] = pendM[t] & ~xGrant[t];
      end
    end
  endtask

  task automatic step();
    modelPredict();
    driveInputs();
    #1;
    compareOut();
    modelAdvance();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit busy();
    for (int t = 0; t < EP_THREADS; t++)
      if (srcQ[t].size() > 0 || pendM[t] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic runIdle(input int maxSteps);
    int n = 0;
    while (busy() && n < maxSteps) begin step(); n++; end
    step();
    check(!busy(), curReq, "drained", int'(busy()), 0);
  endtask

  initial begin
    for (int t = 0; t < EP_THREADS; t++) begin pendM[t] = '0; heldEp[t] = '0; end
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(issueValid == '0, "R1", "lanes in reset", int'(issueValid), 0);
    check(epBoundary == '0, "R1", "boundary in reset", int'(epBoundary), 0);
    check(epReady == '1, "R1", "ready in reset", int'(epReady), 15);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    step();

    // R2: three ALU ops on thread 0, none issue at capture, split over two cycles
    curReq = "R2";
    srcQ[0].push_back(mkEp(8'h07, 16'h0000));
    runIdle(20);

    // R3: one op of each kind lands in its own group in one cycle
    curReq = "R3";
    srcQ[0].push_back(mkEp(8'h0F, 16'h00E4));
    runIdle(20);

    // R5: two multiplies at slots 2 and 5 with one multiplier; full mixed EP
    curReq = "R5";
    srcQ[0].push_back(mkEp(8'h24, 16'h0820));
    srcQ[0].push_back(mkEp(8'hFF, 16'hE4E4));
    runIdle(20);

    // R4: four threads fight for two ALUs
    curReq = "R4";
    for (int t = 0; t < EP_THREADS; t++) srcQ[t].push_back(mkEp(8'h0F, 16'h0000));
    srcQ[3].push_back(mkEp(8'h03, 16'h00F0));
    runIdle(40);

    // R6: back-to-back single-op packets on thread 1 against shifter pressure
    curReq = "R6";
    for (int i = 0; i < 3; i++) srcQ[1].push_back(mkEp(8'h01, 16'h0001));
    srcQ[0].push_back(mkEp(8'h03, 16'h0005));
    srcQ[1].push_back(mkEp(8'h03, 16'h0000));
    runIdle(30);

    // R9: empty packet on thread 2, thread 3 idle
    curReq = "R9";
    srcQ[2].push_back(mkEp(8'h00, 16'h0000));
    srcQ[2].push_back(mkEp(8'h01, 16'h0003));
    runIdle(20);

    // R10: random traffic with bubbles and garbage on held threads
    curReq = "R10";
    allowBubble = 1;
    for (int i = 0; i < 80; i++) begin
      int t = int'($urandom % EP_THREADS);
      logic [EP_SLOTS-1:0] m = (i % 13 == 0) ? 8'h00 : EP_SLOTS'($urandom);
      srcQ[t].push_back(mkEp(m, 16'($urandom)));
    end
    runIdle(3000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule